// File: doc/BRIEF.md
# Signed-by-Unsigned Fractional Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for fixed-point signal processing. It multiplies a signed two's-complement fraction by an unsigned fraction, both 16 bits wide. The second operand's code $8000 therefore stands for +1.0 and not -1.0. The block doubles the raw integer product to form the fractional product, sign-extends it to the full accumulator width and adds it to a running sum.

The sum is 36 bits wide: a 4-bit guard field, then a 16-bit upper word, then a 16-bit lower word. On a strobe, the result goes to one of two places. Normally it goes to the accumulator. In narrow mode it goes to a separate 16-bit register, which keeps only the upper word of the sum. Each operation also produces six status flags: negative, zero, overflow, a sticky overflow (limit), guard-in-use, and unnormalised.

The unit never saturates the result. It is used as the execution stage behind a decoder that supplies operands and selects the destination.

Top module: `sumac_unit`

## Requirements
- R1: When `valid_i` is high and `dest16_i` is low, `acc_o` takes the value (acc + 2·(S·U)) mod 2^36 on the clock edge. S is `op_s_i` read as signed. U is `op_u_i` read as unsigned. The doubled product is sign-extended to 36 bits before the add.
- R2: With `op_s_i`=$3456, `op_u_i`=$8000 and an accumulator of $0_0000_0099, the accumulator becomes $0_3456_0099.
- R3: When `valid_i` and `dest16_i` are both high, the 36-bit sum is formed with the addend {sign-extension, `dreg_o`, 16'h0}. Bits [31:16] of that sum are written to `dreg_o`, and `acc_o` is left unchanged. Loss of the sign in this narrow copy is not flagged as an error.
- R4: `sat_mode_i` has no effect on any output.
- R5: After an operation, `n_o` equals bit 35 of the 36-bit sum, and `z_o` is 1 exactly when the whole sum is zero.
- R6: `v_o` is 1 after an operation whose signed 36-bit add overflowed, and 0 after every other operation.
- R7: `e_o` is 0 exactly when bits [35:31] of the sum are all equal.
- R8: `u_o` is 1 exactly when bits 31 and 30 of the sum are equal.
- R9: `l_o` is sticky. An overflowing operation sets it. It stays set until `lclr_i` is high on a clock edge, which clears it whether or not `valid_i` is high. If the same edge also carries an overflowing operation, `l_o` ends up set.
- R10: When `valid_i` is low, `acc_o`, `dreg_o` and all flags other than a cleared `l_o` hold their values.
- R11: While `rst_n` is low, the accumulator, the narrow register and every flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| dest16_i | input | 1 | Select the 16-bit narrow destination |
| sat_mode_i | input | 1 | Saturation-mode bit, ignored |
| lclr_i | input | 1 | Clear the sticky limit flag |
| op_s_i | input | 16 | Signed fractional operand |
| op_u_i | input | 16 | Unsigned fractional operand |
| acc_o | output | 36 | Accumulator: guard, upper, lower |
| dreg_o | output | 16 | Narrow destination register |
| l_o | output | 1 | Sticky overflow (limit) flag |
| e_o | output | 1 | Guard bits in use |
| u_o | output | 1 | Unnormalised |
| n_o | output | 1 | Negative |
| z_o | output | 1 | Zero |
| v_o | output | 1 | Overflow of this operation |

## Verification
The bench targets six corner cases:
- **$8000 as the unsigned operand.** A design that read it as signed would subtract instead of add.
- **The largest product, accumulated until the signed 36-bit range wraps.** A design with a wrong overflow test, or one that limits the result, would show a wrong `v_o` or a clamped accumulator.
- **Narrow-mode accumulation whose upper word turns negative from a positive sum.** A design that flagged this, or that disturbed `acc_o`, would be caught.
- **The saturation-mode input held high while an overflow occurs.**
- **The limit flag across a non-overflowing operation and a clear with no strobe.** A design that rewrote the flag on every operation, or that ignored the clear without `valid_i`, would fail here.
- **Zero, negative and guard results.** These check that Z, N, E and U are taken from the correct bits.

// File: rtl/sumac_pkg.sv
package sumac_pkg;
  typedef struct packed {
    logic lim;
    logic ext;
    logic unn;
    logic neg;
    logic zer;
    logic ovf;
  } sumac_flags_t;
endpackage

// File: rtl/sumac_mul.sv
// Signed x unsigned multiplier producing the doubled (fractional) product,
// sign-extended to the accumulator width.
module sumac_mul #(
  parameter int OPW  = 16,
  parameter int ACCW = 36
) (
  input  logic [OPW-1:0]  op_s,
  input  logic [OPW-1:0]  op_u,
  output logic [ACCW-1:0] prod
);
  localparam int RAWW = 2 * OPW + 2;

  logic signed [OPW:0]    a_ext;
  logic signed [OPW:0]    b_ext;
  logic signed [RAWW-1:0] raw;

  always_comb begin
    a_ext = {op_s[OPW-1], op_s};
    b_ext = {1'b0, op_u};
    raw   = RAWW'(a_ext) * RAWW'(b_ext);
  end

  generate
    if (ACCW > RAWW) begin : g_wide
      logic [ACCW-1:0] raw_ext;
      always_comb raw_ext = {{(ACCW-RAWW){raw[RAWW-1]}}, raw};
      always_comb prod = {raw_ext[ACCW-2:0], 1'b0};
    end else begin : g_narrow
      always_comb prod = {raw[ACCW-2:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/sumac_add.sv
// Wrapping signed adder with an overflow indication.
module sumac_add #(
  parameter int ACCW = 36
) (
  input  logic [ACCW-1:0] a,
  input  logic [ACCW-1:0] b,
  output logic [ACCW-1:0] sum,
  output logic            ovf
);
  always_comb begin
    sum = a + b;
    ovf = (a[ACCW-1] == b[ACCW-1]) && (sum[ACCW-1] != a[ACCW-1]);
  end
endmodule

// File: rtl/sumac_flag.sv
// Result-derived condition bits.
module sumac_flag #(
  parameter int OPW  = 16,
  parameter int ACCW = 36
) (
  input  logic [ACCW-1:0] res,
  output logic            neg,
  output logic            zer,
  output logic            ext,
  output logic            unn
);
  localparam int PW = 2 * OPW;

  logic [ACCW-PW:0] top_bits;

  always_comb begin
    top_bits = res[ACCW-1:PW-1];
    neg      = res[ACCW-1];
    zer      = (res == '0);
    ext      = !((&top_bits) || !(|top_bits));
    unn      = (res[PW-1] == res[PW-2]);
  end
endmodule

// File: rtl/sumac_unit.sv
module sumac_unit #(
  parameter int OPW  = 16,
  parameter int EXTW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic                    dest16_i,
  input  logic                    sat_mode_i,
  input  logic                    lclr_i,
  input  logic [OPW-1:0]          op_s_i,
  input  logic [OPW-1:0]          op_u_i,
  output logic [EXTW+2*OPW-1:0]   acc_o,
  output logic [OPW-1:0]          dreg_o,
  output logic                    l_o,
  output logic                    e_o,
  output logic                    u_o,
  output logic                    n_o,
  output logic                    z_o,
  output logic                    v_o
);
  import sumac_pkg::*;

  localparam int ACCW = EXTW + 2 * OPW;

  logic [ACCW-1:0] acc_q, acc_d;
  logic [OPW-1:0]  dreg_q, dreg_d;
  sumac_flags_t    flg_q, flg_d;

  logic [ACCW-1:0] prod, addend, sum;
  logic            add_ovf, f_neg, f_zer, f_ext, f_unn;
  logic            sat_unused;

  // Saturation mode is accepted for interface compatibility only.
  always_comb sat_unused = sat_mode_i;

  always_comb begin
    if (dest16_i) addend = {{EXTW{dreg_q[OPW-1]}}, dreg_q, {OPW{1'b0}}};
    else          addend = acc_q;
  end

  sumac_mul  #(.OPW(OPW), .ACCW(ACCW)) u_mul (
    .op_s(op_s_i), .op_u(op_u_i), .prod(prod));

  sumac_add  #(.ACCW(ACCW)) u_add (
    .a(addend), .b(prod), .sum(sum), .ovf(add_ovf));

  sumac_flag #(.OPW(OPW), .ACCW(ACCW)) u_flag (
    .res(sum), .neg(f_neg), .zer(f_zer), .ext(f_ext), .unn(f_unn));

  // Next-state
  always_comb begin
    acc_d  = acc_q;
    dreg_d = dreg_q;
    flg_d  = flg_q;
    if (lclr_i) flg_d.lim = 1'b0;
    if (valid_i) begin
      if (dest16_i) dreg_d = sum[2*OPW-1:OPW];
      else          acc_d  = sum;
      flg_d.ext = f_ext;
      flg_d.unn = f_unn;
      flg_d.neg = f_neg;
      flg_d.zer = f_zer;
      flg_d.ovf = add_ovf;
      flg_d.lim = flg_d.lim | add_ovf;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dreg_q <= '0;
      flg_q  <= '0;
    end else begin
      if (valid_i) begin
        acc_q  <= acc_d;
        dreg_q <= dreg_d;
      end
      if (valid_i || lclr_i) flg_q <= flg_d;
    end
  end

  always_comb begin
    acc_o  = acc_q;
    dreg_o = dreg_q;
    l_o    = flg_q.lim;
    e_o    = flg_q.ext;
    u_o    = flg_q.unn;
    n_o    = flg_q.neg;
    z_o    = flg_q.zer;
    v_o    = flg_q.ovf;
  end
endmodule

// File: rtl/sumac_chk.sv
module sumac_chk #(
  parameter int OPW  = 16,
  parameter int EXTW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  valid_i,
  input logic                  dest16_i,
  input logic                  lclr_i,
  input logic [EXTW+2*OPW-1:0] acc_o,
  input logic [OPW-1:0]        dreg_o,
  input logic                  l_o,
  input logic                  e_o,
  input logic                  u_o,
  input logic                  n_o,
  input logic                  z_o,
  input logic                  v_o
);
  localparam int ACCW = EXTW + 2 * OPW;
  localparam int PW   = 2 * OPW;

  // R3: narrow destination leaves the accumulator alone
  a_r3_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && dest16_i |=> $stable(acc_o));
  // R3: wide destination leaves the narrow register alone
  a_r3_dreg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !dest16_i |=> $stable(dreg_o));
  // R10: no strobe, no datapath change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(acc_o) && $stable(dreg_o) && $stable(v_o) && $stable(n_o));
  // R5: negative and zero agree with the stored accumulator
  a_r5_nz: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !dest16_i |=> (n_o == acc_o[ACCW-1]) && (z_o == (acc_o == '0)));
  // R7: guard-in-use agrees with the stored accumulator
  a_r7_ext: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !dest16_i |=> e_o == !((&acc_o[ACCW-1:PW-1]) || !(|acc_o[ACCW-1:PW-1])));
  // R8: unnormalised agrees with the stored accumulator
  a_r8_unn: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !dest16_i |=> u_o == (acc_o[PW-1] == acc_o[PW-2]));
  // R9: sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    l_o && !lclr_i |=> l_o);
  // R9: clear without operation empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lclr_i && !valid_i |=> !l_o);
  // R6/R9: an overflow always leaves the limit flag set
  a_r6_v_sets_l: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (!v_o || l_o));
endmodule

bind sumac_unit sumac_chk #(.OPW(OPW), .EXTW(EXTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dest16_i(dest16_i),
  .lclr_i(lclr_i), .acc_o(acc_o), .dreg_o(dreg_o), .l_o(l_o), .e_o(e_o),
  .u_o(u_o), .n_o(n_o), .z_o(z_o), .v_o(v_o));

// File: tb/sumac_unit_test.sv
module sumac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, dest16_i, sat_mode_i, lclr_i;
  logic [15:0] op_s_i, op_u_i;
  logic [35:0] acc_o;
  logic [15:0] dreg_o;
  logic        l_o, e_o, u_o, n_o, z_o, v_o;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [35:0] m_acc;
  logic [15:0] m_dreg;
  logic        m_l, m_e, m_u, m_n, m_z, m_v;

  always #5 clk = ~clk;

  sumac_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dest16_i(dest16_i),
    .sat_mode_i(sat_mode_i), .lclr_i(lclr_i), .op_s_i(op_s_i), .op_u_i(op_u_i),
    .acc_o(acc_o), .dreg_o(dreg_o), .l_o(l_o), .e_o(e_o), .u_o(u_o),
    .n_o(n_o), .z_o(z_o), .v_o(v_o));

  task automatic chk(input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "acc",  acc_o,  m_acc);
    chk(req, "dreg", {20'h0, dreg_o}, {20'h0, m_dreg});
    chk(req, "flags LEUNZV", {30'h0, l_o, e_o, u_o, n_o, z_o, v_o},
        {30'h0, m_l, m_e, m_u, m_n, m_z, m_v});
  endtask

  // Model of one strobe per the requirements (R1, R3, R5-R9).
  task automatic model_op(input logic [15:0] s, input logic [15:0] u,
                          input logic d16, input logic clr);
    longint prod, add, sum;
    logic [35:0] r;
    logic ov;
    prod = longint'($signed(s)) * longint'(u) * 64'sd2;
    if (d16) add = longint'($signed(m_dreg)) * 64'sd65536;
    else     add = longint'($signed(m_acc));
    sum = add + prod;
    ov  = (sum > 64'sd34359738367) || (sum < -64'sd34359738368);
    r   = sum[35:0];
    if (d16) m_dreg = r[31:16]; else m_acc = r;
    m_n = r[35];
    m_z = (r == 36'h0);
    m_v = ov;
    m_e = !(r[35:31] == 5'b00000 || r[35:31] == 5'b11111);
    m_u = (r[31] == r[30]);
    m_l = (clr ? 1'b0 : m_l) | ov;
  endtask

  task automatic step(input logic [15:0] s, input logic [15:0] u,
                      input logic d16, input logic sat, input logic clr,
                      input logic v);
    @(negedge clk);
    op_s_i = s; op_u_i = u; dest16_i = d16; sat_mode_i = sat;
    lclr_i = clr; valid_i = v;
    if (v) model_op(s, u, d16, clr);
    else if (clr) m_l = 1'b0;
    @(negedge clk);
    valid_i = 1'b0; lclr_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid_i = 1'b0; dest16_i = 1'b0; sat_mode_i = 1'b0; lclr_i = 1'b0;
    op_s_i = 16'hFFFF; op_u_i = 16'hFFFF;
    m_acc = '0; m_dreg = '0;
    {m_l, m_e, m_u, m_n, m_z, m_v} = '0;
    repeat (3) @(negedge clk);
    chk_all("R11");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1, R2: doc example, $8000 unsigned = +1.0
  task automatic t_example();
    step(16'h0099, 16'h0080, 1'b0, 1'b0, 1'b0, 1'b1); // 0x99*0x80*2 = 0x9900
    chk_all("R1");
    step(16'h0099, 16'h0080, 1'b0, 1'b0, 1'b0, 1'b0);
    do_reset();
    // load 0x99: 0x0099 * 0x0001 *2 = 0x132 -> use s=0x0099,u=0x8000>>? build directly
    step(16'h0001, 16'h004C, 1'b0, 1'b0, 1'b0, 1'b1); // 0x98
    step(16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1); // +0
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1); // -0x1FFFE
    step(16'h0001, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1); // +0x1FFFE
    chk("R2", "acc 0x98", acc_o, 36'h0_0000_0098);
    // bring to 0x99: no odd product exists, so reset and preload via narrow path impossible;
    // instead check example relative: add 0x3456*0x8000
    step(16'h3456, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", "acc after $3456*$8000", acc_o, 36'h0_3456_0098);
    chk_all("R2");
    // negative signed times $8000 subtracts
    step(16'hCBAA, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", "acc back", acc_o, 36'h0_0000_0098);
    chk_all("R1");
  endtask

  // R5, R7, R8: zero, negative, guard use
  task automatic t_flags();
    step(16'hFFFF, 16'h004C, 1'b0, 1'b0, 1'b0, 1'b1); // -0x98 -> zero
    chk_all("R5");
    chk("R5", "z", {35'h0, z_o}, 36'h1);
    step(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1); // -2 -> negative
    chk_all("R5");
    chk("R8", "u", {35'h0, u_o}, 36'h1);
    for (int i = 0; i < 3; i++) step(16'h7FFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_all("R7");
    chk("R7", "e", {35'h0, e_o}, 36'h1);
  endtask

  // R3: narrow destination, sign lost silently
  task automatic t_dest16();
    logic [35:0] keep;
    keep = acc_o;
    step(16'h7FFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    chk_all("R3");
    chk("R3", "dreg", {20'h0, dreg_o}, 36'h0_0000_FFFD);
    chk("R3", "acc untouched", acc_o, keep);
    step(16'h0100, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk_all("R3");
  endtask

  // R6, R9, R4: overflow, sticky limit, saturation ignored
  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) step(16'h7FFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    chk_all("R6");
    chk("R6", "no ovf yet", {35'h0, v_o}, 36'h0);
    step(16'h7FFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    chk_all("R4");
    chk("R6", "v set", {35'h0, v_o}, 36'h1);
    step(16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_all("R9");
    chk("R9", "l sticky", {35'h0, l_o}, 36'h1);
    // R10: no strobe holds everything
    step(16'h1234, 16'h5678, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_all("R10");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_all("R9");
    chk("R9", "l cleared", {35'h0, l_o}, 36'h0);
  endtask

  initial begin
    do_reset();
    t_example();
    t_flags();
    t_dest16();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule